// File: doc/BRIEF.md
# Frequency Gate Timing Sequencer

This block paces a direct-count frequency measurement from a single reference clock. It runs a repeating loop. It clears the external event counter for one cycle and then waits through a fixed quiet interval. It then opens the counting gate for an exact number of reference cycles and, when the gate closes, flags for one cycle that the count is ready. The gate lamp output follows the gate. The quiet interval therefore makes the lamp blink once per refresh.

The gate interval depends on the selected channel. The prescaled high-frequency path uses 640 ms and the direct path uses 1 s. A stretch flag makes either interval ten times longer. All intervals are counted in reference cycles. `TICKS_PER_MS` defaults to 12800 for a 12.8 MHz reference and can be lowered to shorten runs.

A hold pulse asks the loop to stop. The measurement in progress still finishes and reports, and the block then stays idle. A second hold pulse restarts the loop. Any change to the channel select or the stretch flag during the quiet interval or the gate abandons that measurement and starts again with a clear.

Top module: `freq_gate_seq`

## Requirements
- R1: While `rst_n` is low, `cnt_clr` is 1 and `gate`, `lamp` and `result_valid` are 0.
- R2: Each loop asserts `cnt_clr` for exactly one cycle. Then follow exactly `PAUSE_MS*TICKS_PER_MS` cycles in which `cnt_clr`, `gate`, `lamp` and `result_valid` are all 0, and then `gate` rises.
- R3: With `direct_sel`=0 and `expand`=0, `gate` stays high for exactly `PRESC_GATE_MS*TICKS_PER_MS` cycles.
- R4: With `direct_sel`=1 and `expand`=0, `gate` stays high for exactly `DIRECT_GATE_MS*TICKS_PER_MS` cycles.
- R5: With `expand`=1, the gate length of either channel is multiplied by `EXPAND_FACTOR` (10).
- R6: `lamp` is 1 in exactly the cycles in which `gate` is 1.
- R7: `result_valid` is 1 for exactly one cycle, the cycle right after `gate` falls at the end of a full gate interval. If hold is not requested, `cnt_clr` is 1 in the next cycle and the loop repeats.
- R8: A change of `direct_sel` or `expand` during the quiet interval or the gate ends the measurement. `cnt_clr` is 1 in the next cycle, `gate` is 0 and no `result_valid` is produced for that measurement.
- R9: A one-cycle `hold_press` during a measurement does not shorten it. The measurement still ends with `result_valid`, after which all four outputs stay 0. A configuration change while idle in this way starts nothing.
- R10: While idle on hold, a further one-cycle `hold_press` makes `cnt_clr` 1 in the next cycle, and the new loop uses the configuration present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all timing counts its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| direct_sel | input | 1 | 0: prescaled channel gate, 1: direct channel gate |
| expand | input | 1 | 1: gate interval stretched by `EXPAND_FACTOR` |
| hold_press | input | 1 | One-cycle pulse toggling the hold request |
| cnt_clr | output | 1 | Clear strobe for the external event counter |
| gate | output | 1 | Counting gate enable |
| lamp | output | 1 | Gate indicator lamp drive |
| result_valid | output | 1 | One-cycle pulse: count is complete |

## Verification
The checker assumes that `hold_press` arrives as an isolated one-cycle pulse from a debounced source. A held-down level would toggle the request every cycle. The checker also assumes that the channel select and stretch flag change only on purpose, since every change counts as an abort. The stimulus applies each hold press for exactly one cycle. It changes the configuration only in three places: while the clear strobe is high, at a deliberate abort point, or while the block is idle on hold. Each gate interval a check sees therefore has a single known configuration.

// File: rtl/freq_gate_seq.sv
module freq_gate_seq #(
  parameter int TICKS_PER_MS   = 12800,
  parameter int PAUSE_MS       = 30,
  parameter int PRESC_GATE_MS  = 640,
  parameter int DIRECT_GATE_MS = 1000,
  parameter int EXPAND_FACTOR  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic direct_sel,
  input  logic expand,
  input  logic hold_press,
  output logic cnt_clr,
  output logic gate,
  output logic lamp,
  output logic result_valid
);
  localparam int PAUSE_LEN  = PAUSE_MS * TICKS_PER_MS;
  localparam int PRESC_LEN  = PRESC_GATE_MS * TICKS_PER_MS;
  localparam int DIRECT_LEN = DIRECT_GATE_MS * TICKS_PER_MS;
  localparam int BASE_MAX   = (PRESC_LEN > DIRECT_LEN) ? PRESC_LEN : DIRECT_LEN;
  localparam int MAX_LEN    = BASE_MAX * EXPAND_FACTOR;
  localparam int TW         = $clog2(MAX_LEN + 1);

  localparam logic [TW-1:0] L_PAUSE = TW'(PAUSE_LEN - 1);
  localparam logic [TW-1:0] L_PRE   = TW'(PRESC_LEN - 1);
  localparam logic [TW-1:0] L_DIR   = TW'(DIRECT_LEN - 1);
  localparam logic [TW-1:0] L_PRE_X = TW'(PRESC_LEN * EXPAND_FACTOR - 1);
  localparam logic [TW-1:0] L_DIR_X = TW'(DIRECT_LEN * EXPAND_FACTOR - 1);

  typedef enum logic [2:0] {S_CLR, S_PAUSE, S_GATE, S_DONE, S_IDLE} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [TW-1:0] gate_load;
  logic [1:0]    cfg_q;
  logic          hold_q;

  wire  [1:0] cfg     = {direct_sel, expand};
  wire        cfg_chg = cfg != cfg_q;
  wire        hold_nx = hold_q ^ hold_press;
  wire        tmr_end = tmr == '0;

  always_comb begin
    case (cfg)
      2'b00:   gate_load = L_PRE;
      2'b01:   gate_load = L_PRE_X;
      2'b10:   gate_load = L_DIR;
      default: gate_load = L_DIR_X;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_CLR;
      tmr    <= '0;
      cfg_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cfg_q  <= cfg;
      hold_q <= hold_nx;
      case (st)
        S_CLR: begin
          st  <= S_PAUSE;
          tmr <= L_PAUSE;
        end
        S_PAUSE: begin
          if (cfg_chg) st <= S_CLR;
          else if (tmr_end) begin
            st  <= S_GATE;
            tmr <= gate_load;
          end else tmr <= tmr - 1'b1;
        end
        S_GATE: begin
          if (cfg_chg)      st <= S_CLR;
          else if (tmr_end) st <= S_DONE;
          else              tmr <= tmr - 1'b1;
        end
        S_DONE:  st <= hold_nx ? S_IDLE : S_CLR;
        default: if (!hold_nx) st <= S_CLR;
      endcase
    end
  end

  assign cnt_clr      = st == S_CLR;
  assign gate         = st == S_GATE;
  assign lamp         = st == S_GATE;
  assign result_valid = st == S_DONE;
endmodule

module freq_gate_seq_chk #(
  parameter int TICKS_PER_MS   = 12800,
  parameter int PAUSE_MS       = 30,
  parameter int PRESC_GATE_MS  = 640,
  parameter int DIRECT_GATE_MS = 1000,
  parameter int EXPAND_FACTOR  = 10
) (
  input logic clk,
  input logic rst_n,
  input logic direct_sel,
  input logic expand,
  input logic hold_press,
  input logic cnt_clr,
  input logic gate,
  input logic lamp,
  input logic result_valid
);
  localparam int PAUSE_LEN = PAUSE_MS * TICKS_PER_MS;

  int   gcnt, pcnt, exp_q;
  logic held_c, idle_c;
  wire  held_nx = held_c ^ hold_press;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt <= 0; pcnt <= 0; exp_q <= 0; held_c <= 1'b0; idle_c <= 1'b0;
    end else begin
      gcnt   <= gate ? gcnt + 1 : 0;
      pcnt   <= cnt_clr ? 0 : (!gate ? pcnt + 1 : pcnt);
      exp_q  <= (direct_sel ? DIRECT_GATE_MS : PRESC_GATE_MS) * TICKS_PER_MS
                * (expand ? EXPAND_FACTOR : 1);
      held_c <= held_nx;
      idle_c <= held_nx && (result_valid || idle_c);
    end
  end

  // R2
  p_pause_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> pcnt == PAUSE_LEN);
  // R3, R4, R5
  p_gate_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> gcnt == exp_q);
  p_valid_after_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(gate) && !gate);
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  p_abort_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate) && !gate && !result_valid) |-> cnt_clr);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((result_valid || idle_c) && held_nx) |=> !cnt_clr && !gate && !lamp);
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_c && !held_nx) |=> cnt_clr);
endmodule

bind freq_gate_seq freq_gate_seq_chk #(
  .TICKS_PER_MS(TICKS_PER_MS), .PAUSE_MS(PAUSE_MS), .PRESC_GATE_MS(PRESC_GATE_MS),
  .DIRECT_GATE_MS(DIRECT_GATE_MS), .EXPAND_FACTOR(EXPAND_FACTOR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .direct_sel(direct_sel), .expand(expand),
  .hold_press(hold_press), .cnt_clr(cnt_clr), .gate(gate), .lamp(lamp),
  .result_valid(result_valid)
);

// File: tb/sim_freq_gate_seq.sv
`timescale 1ns/1ps
module sim_freq_gate_seq;
  localparam int T = 2, PMS = 30, PRE = 640, DIR = 1000, XF = 10;

  logic clk = 1'b0, rst_n = 1'b0, direct_sel = 1'b0, expand = 1'b0, hold_press = 1'b0;
  logic cnt_clr, gate, lamp, result_valid;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  freq_gate_seq #(.TICKS_PER_MS(T)) u0 (
    .clk(clk), .rst_n(rst_n), .direct_sel(direct_sel), .expand(expand),
    .hold_press(hold_press), .cnt_clr(cnt_clr), .gate(gate), .lamp(lamp),
    .result_valid(result_valid)
  );

  function automatic int exp_gate(logic d, logic x);
    return (d ? DIR : PRE) * T * (x ? XF : 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // entered at a negedge where cnt_clr is 1
  task automatic run_cycle(input int hold_at, input bit idle_after);
    int pc = 0, gc = 0, bad = 0;
    int g = exp_gate(direct_sel, expand);
    string req = direct_sel ? (expand ? "R4 R5 gate length" : "R4 gate length")
                            : (expand ? "R3 R5 gate length" : "R3 gate length");
    @(negedge clk);
    while (gate === 1'b0 && pc < PMS * T + 20) begin
      if (cnt_clr !== 1'b0 || result_valid !== 1'b0 || lamp !== 1'b0) bad++;
      pc++;
      @(negedge clk);
    end
    chk("R2 pause length", pc, PMS * T);
    chk("R2 outputs quiet in pause", bad, 0);
    bad = 0;
    while (gate === 1'b1 && gc < g + 20) begin
      if (lamp !== 1'b1 || cnt_clr !== 1'b0) bad++;
      hold_press = (gc == hold_at);
      gc++;
      @(negedge clk);
    end
    hold_press = 1'b0;
    chk(req, gc, g);
    chk("R6 lamp tracks gate", bad, 0);
    chk("R7 valid after gate", result_valid, 1);
    chk("R6 lamp off after gate", lamp, 0);
    @(negedge clk);
    chk("R7 valid single cycle", result_valid, 0);
    if (idle_after) chk("R9 no restart while held", cnt_clr, 0);
    else            chk("R7 loop restarts with clear", cnt_clr, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk("R1 reset cnt_clr", cnt_clr, 1);
    chk("R1 reset gate", gate, 0);
    chk("R1 reset lamp", lamp, 0);
    chk("R1 reset valid", result_valid, 0);
    rst_n = 1'b1;

    run_cycle(-1, 1'b0);
    for (int d = 0; d < 2; d++) begin
      for (int x = 0; x < 2; x++) begin
        direct_sel = d[0];
        expand     = x[0];
        run_cycle(-1, 1'b0);
      end
    end

    // abort during gate (config now 1,1)
    while (gate !== 1'b1) @(negedge clk);
    repeat (10) @(negedge clk);
    expand = 1'b0;
    @(negedge clk);
    chk("R8 abort in gate clears", cnt_clr, 1);
    chk("R8 abort in gate closes", gate, 0);
    chk("R8 abort in gate no valid", result_valid, 0);
    run_cycle(-1, 1'b0);

    // abort during pause
    repeat (6) @(negedge clk);
    direct_sel = 1'b0;
    @(negedge clk);
    chk("R8 abort in pause clears", cnt_clr, 1);
    chk("R8 abort in pause no gate", gate, 0);
    run_cycle(-1, 1'b0);

    // hold mid-gate, then idle, then release
    run_cycle(5, 1'b1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == 20) expand = 1'b1;
      if (cnt_clr !== 1'b0 || gate !== 1'b0 || lamp !== 1'b0 || result_valid !== 1'b0) bad++;
      @(negedge clk);
    end
    chk("R9 idle while held", bad, 0);
    hold_press = 1'b1;
    @(negedge clk);
    hold_press = 1'b0;
    chk("R10 release restarts with clear", cnt_clr, 1);
    run_cycle(-1, 1'b0);

    finish_run();
  end
endmodule